// File: doc/BRIEF.md
# Five-State Table-Driven Moore Controller

This block is a small clocked controller that walks through five encoded states under the control of one serial input bit. On every rising clock edge it takes a new state from a fixed transition table. The new state depends on the present state and on the input bit. The block drives two outputs: the present state code, and a one-bit flag. The flag is decoded from the state code alone, so it is a Moore output and does not react to the input between edges.

The transition table and the flag table are each built as an eight-way selector indexed by the state code. The state register is a separate module. Codes that the table does not use are tied off, so they lead back to the idle state and hold the flag low. A synchronous reset returns the machine to the idle state.

Top module: `moore5_top`

## Requirements
- R1: With `rst_i` high at a rising edge, `code_o` becomes 000 and `flag_o` becomes 0 after that edge, whatever `bit_i` is.
- R2: From state 000, an edge with `bit_i`=0 keeps the state at 000, and an edge with `bit_i`=1 moves it to 001.
- R3: From state 001, `bit_i`=0 keeps 001 and `bit_i`=1 moves to 010.
- R4: From state 010, `bit_i`=0 moves to 001 and `bit_i`=1 moves to 011.
- R5: From state 011, `bit_i`=0 moves to 100 and `bit_i`=1 moves back to 000.
- R6: From state 100, `bit_i`=0 moves to 001 and `bit_i`=1 moves to 010.
- R7: `flag_o` is 1 exactly when `code_o` is 010 or 100, and is 0 in states 000, 001 and 011. Changing `bit_i` between edges has no effect on `flag_o` or `code_o`.
- R8: After reset, `code_o` never takes a value above 100 for any input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset to state 000 |
| bit_i | input | 1 | Serial control bit sampled at each edge |
| code_o | output | CODE_W (3) | Present state code |
| flag_o | output | 1 | Moore output decoded from the present state |

## Verification
Every state is reached with short directed prefixes from reset: 1 leads to 001, 11 to 010, 111 to 011, and 1110 to 100. Each state is then stepped once with 0 and once with 1, which separates the two table columns for that row. A toggle of `bit_i` between edges in one flag-low state and one flag-high state separates a Moore decode from a decode that leaks the input. A long pseudo-random walk, compared against a model in the bench, shows that the state never leaves the legal range and that reset taken in the middle of the walk still returns the machine to 000.

// File: rtl/moore5_pkg.sv
package moore5_pkg;
   // Legal state codes; the order matters because the table is indexed by them
   localparam int ST_IDLE = 0;
   localparam int ST_ARM  = 1;
   localparam int ST_HIT  = 2;
   localparam int ST_PEAK = 3;
   localparam int ST_ECHO = 4;

   // Next state for a row of the table; unused rows fall back to idle
   function automatic int row_next(input int row, input bit b);
      case (row)
         ST_IDLE: return b ? ST_ARM  : ST_IDLE;
         ST_ARM:  return b ? ST_HIT  : ST_ARM;
         ST_HIT:  return b ? ST_PEAK : ST_ARM;
         ST_PEAK: return b ? ST_IDLE : ST_ECHO;
         ST_ECHO: return b ? ST_HIT  : ST_ARM;
         default: return ST_IDLE;
      endcase
   endfunction

   // Moore output for a row of the table
   function automatic bit row_flag(input int row);
      return (row == ST_HIT) || (row == ST_ECHO);
   endfunction
endpackage

// File: rtl/moore5_sel.sv
module moore5_sel #(
   parameter int W    = 1,
   parameter int SW   = 3,
   parameter int IMPL = 0
) (
   input  logic [(2**SW)*W-1:0] tbl_i,
   input  logic [SW-1:0]        sel_i,
   output logic [W-1:0]         y_o
);
   localparam int N = 2**SW;

   if (W < 1 || SW < 1) begin : g_bad
      $error("moore5_sel: W and SW must be positive");
   end

   if (IMPL == 0) begin : g_index
      assign y_o = tbl_i[W*int'(sel_i) +: W];
   end else begin : g_scan
      always_comb begin
         y_o = '0;
         for (int k = 0; k < N; k++) begin
            if (int'(sel_i) == k) y_o = tbl_i[k*W +: W];
         end
      end
   end
endmodule

// File: rtl/moore5_reg.sv
module moore5_reg #(
   parameter int W       = 3,
   parameter int RST_VAL = 0
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i) q_o <= W'(RST_VAL);
      else       q_o <= d_i;
   end
endmodule

// File: rtl/moore5_top.sv
module moore5_top
   import moore5_pkg::*;
#(
   parameter int CODE_W   = 3,
   parameter int SEL_IMPL = 0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              bit_i,
   output logic [CODE_W-1:0] code_o,
   output logic              flag_o
);
   localparam int ROWS  = 2**CODE_W;
   localparam int PAIRW = 2*CODE_W;

   if (CODE_W < 3 || CODE_W > 5) begin : g_bad_w
      $error("moore5_top: CODE_W must lie in 3..5");
   end

   logic [ROWS*PAIRW-1:0] nxt_tbl;
   logic [ROWS-1:0]       flg_tbl;
   logic [PAIRW-1:0]      nxt_pair;
   logic [CODE_W-1:0]     nxt_code;

   // Tables are computed from the package functions, one row per code
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign nxt_tbl[r*PAIRW +: PAIRW] = {CODE_W'(row_next(r, 1'b1)),
                                          CODE_W'(row_next(r, 1'b0))};
      assign flg_tbl[r] = row_flag(r);
   end

   moore5_sel #(.W(PAIRW), .SW(CODE_W), .IMPL(SEL_IMPL)) u_nxt_sel (
      .tbl_i (nxt_tbl),
      .sel_i (code_o),
      .y_o   (nxt_pair)
   );

   assign nxt_code = bit_i ? nxt_pair[PAIRW-1:CODE_W] : nxt_pair[CODE_W-1:0];

   moore5_reg #(.W(CODE_W), .RST_VAL(ST_IDLE)) u_state (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (nxt_code),
      .q_o   (code_o)
   );

   moore5_sel #(.W(1), .SW(CODE_W), .IMPL(SEL_IMPL)) u_flg_sel (
      .tbl_i (flg_tbl),
      .sel_i (code_o),
      .y_o   (flag_o)
   );
endmodule

// File: rtl/moore5_chk.sv
module moore5_chk #(
   parameter int CODE_W = 3
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              bit_i,
   input logic [CODE_W-1:0] code_o,
   input logic              flag_o
);
   localparam logic [CODE_W-1:0] C0 = CODE_W'(0);
   localparam logic [CODE_W-1:0] C1 = CODE_W'(1);
   localparam logic [CODE_W-1:0] C2 = CODE_W'(2);
   localparam logic [CODE_W-1:0] C3 = CODE_W'(3);
   localparam logic [CODE_W-1:0] C4 = CODE_W'(4);

   assert_reset_idle_R1: assert property (@(posedge clk_i)
      rst_i |=> (code_o == C0 && !flag_o));

   assert_idle_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (code_o == C0) |=> (code_o == ($past(bit_i) ? C1 : C0)));

   assert_arm_step_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (code_o == C1) |=> (code_o == ($past(bit_i) ? C2 : C1)));

   assert_hit_step_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (code_o == C2) |=> (code_o == ($past(bit_i) ? C3 : C1)));

   assert_peak_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (code_o == C3) |=> (code_o == ($past(bit_i) ? C0 : C4)));

   assert_echo_step_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (code_o == C4) |=> (code_o == ($past(bit_i) ? C2 : C1)));

   assert_flag_decode_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      flag_o == (code_o == C2 || code_o == C4));

   assert_code_range_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      code_o <= C4);
endmodule

bind moore5_top moore5_chk #(.CODE_W(CODE_W)) u_chk (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .bit_i  (bit_i),
   .code_o (code_o),
   .flag_o (flag_o)
);

// File: tb/moore5_tb_top.sv
module moore5_top_tb_top;
   logic       clk_i = 1'b0;
   logic       rst_i = 1'b1;
   logic       bit_i = 1'b0;
   logic [2:0] code_o;
   logic       flag_o;
   int checks = 0;
   int errors = 0;
   logic       done = 1'b0;

   always #10 clk_i = ~clk_i;

   moore5_top dut_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .bit_i  (bit_i),
      .code_o (code_o),
      .flag_o (flag_o)
   );

   // Reference model written from the requirements
   function automatic logic [2:0] ref_next(input logic [2:0] s, input logic b);
      case (s)
         3'd0: return b ? 3'd1 : 3'd0;
         3'd1: return b ? 3'd2 : 3'd1;
         3'd2: return b ? 3'd3 : 3'd1;
         3'd3: return b ? 3'd0 : 3'd4;
         3'd4: return b ? 3'd2 : 3'd1;
         default: return 3'd0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Drive at the falling edge, step one rising edge, sample 1 ns later
   task automatic step(input logic b, input logic r = 1'b0);
      @(negedge clk_i);
      bit_i = b;
      rst_i = r;
      @(posedge clk_i);
      #1;
   endtask

   task automatic go_reset();
      step(1'b0, 1'b1);
      rst_i = 1'b0;
   endtask

   // Reach state s from reset using the known prefixes
   task automatic reach(input int s);
      go_reset();
      if (s >= 1) step(1'b1);
      if (s >= 2) step(1'b1);
      if (s == 3) step(1'b1);
      if (s == 4) begin step(1'b1); step(1'b0); end
   endtask

   task automatic t_reset_R1();
      step(1'b1, 1'b1);
      chk("R1 code after reset", code_o, 3'd0);
      chk("R1 flag after reset", {2'b0, flag_o}, 3'd0);
      reach(2);
      step(1'b1, 1'b1);
      chk("R1 reset from 010 with bit 1", code_o, 3'd0);
      rst_i = 1'b0;
   endtask

   task automatic t_row(input int s, input string req,
                        input logic [2:0] e0, input logic [2:0] e1);
      reach(s);
      chk({req, " start state"}, code_o, 3'(s));
      step(1'b0);
      chk({req, " bit 0"}, code_o, e0);
      reach(s);
      step(1'b1);
      chk({req, " bit 1"}, code_o, e1);
   endtask

   task automatic t_flag_R7();
      for (int s = 0; s < 5; s++) begin
         reach(s);
         #2;
         chk("R7 flag per state", {2'b0, flag_o}, (s == 2 || s == 4) ? 3'd1 : 3'd0);
      end
      reach(1);
      bit_i = 1'b1; #3;
      chk("R7 flag ignores bit in 001", {2'b0, flag_o}, 3'd0);
      chk("R7 code ignores bit in 001", code_o, 3'd1);
      reach(2);
      bit_i = 1'b0; #3;
      chk("R7 flag ignores bit in 010", {2'b0, flag_o}, 3'd1);
      bit_i = 1'b1; #3;
      chk("R7 code ignores bit in 010", code_o, 3'd2);
   endtask

   task automatic t_walk_R8();
      logic [2:0] model;
      logic [15:0] lfsr = 16'hACE1;
      int bad = 0;
      go_reset();
      model = 3'd0;
      for (int i = 0; i < 400; i++) begin
         logic r;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         r = (i % 97) == 50;
         step(lfsr[0], r);
         model = r ? 3'd0 : ref_next(model, lfsr[0]);
         if (code_o > 3'd4 || code_o !== model) bad++;
      end
      rst_i = 1'b0;
      chk("R8 walk mismatches or out-of-range codes", 3'(bad), 3'd0);
   endtask

   initial begin
      t_reset_R1();
      t_row(0, "R2", 3'd0, 3'd1);
      t_row(1, "R3", 3'd1, 3'd2);
      t_row(2, "R4", 3'd1, 3'd3);
      t_row(3, "R5", 3'd4, 3'd0);
      t_row(4, "R6", 3'd1, 3'd2);
      t_flag_R7();
      t_walk_R8();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk_i);
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule